// File: doc/BRIEF.md
# Lockable dual-clock watchdog timer

A supervision timer whose counter ticks on a slow low-frequency clock while software programs it from a fast bus clock. Every register write that affects the counter is carried across the clock boundary by a toggle handshake. Status outputs show whether the configuration path or the command path is still in flight. A second write to a path that is still in flight is dropped and answered with a one-cycle error response.

Software picks a timeout of 2^(n+3) slow cycles. It can also ask for an early warning and a minimum-feed window, both as quarter fractions of the period. It keeps the counter alive by issuing a clear command. If the counter expires, or if a clear lands too early inside the window, a sticky reset request is raised unless resets are disabled in the configuration. A keyed lock freezes the configuration and the enable state. An input that signals entry into a low-power state aborts a clear that is still in flight. A debug-halt input pauses counting unless the configuration allows counting while halted.

Top module: `wdt_top`

## Requirements
- R1: After rst_ni, all of err_o, ctrl_busy_o, cmd_busy_o, disabling_o, enabled_o, locked_o, warn_o and reset_req_o are low.
- R2: Bus addresses are: configuration 0, command 1, enable-set 2, enable-clear 3, lock 4. An accepted write to address 0, 2 or 3 raises ctrl_busy_o in the next bus cycle. ctrl_busy_o falls once the slow domain has taken the value, within 3 slow periods plus 3 bus cycles.
- R3: A write to address 0, 2 or 3 while ctrl_busy_o is high, with the lock open, is dropped, and err_o pulses high for the next bus cycle.
- R4: Writing 1 in bit 0 of address 1 while enabled issues a clear and raises cmd_busy_o until the slow domain has applied it. A further clear while the first is still in flight is dropped and pulses err_o.
- R5: A clear written while enabled_o is low is ignored: cmd_busy_o stays low and err_o stays low.
- R6: Writing 0x0000A5C3 to address 4 sets locked_o. Writing 0x00003C5A clears it (unless STICKY_LOCK is set), and any other value has no effect. While locked, writes to addresses 0, 2 and 3 change nothing, raise no busy flag and give no error.
- R7: An enable-clear write drops enabled_o in the next cycle and raises disabling_o. disabling_o falls after the slow domain has stopped the counter.
- R8: Configuration bits [3:0] hold n, and the period is 2^(n+3) slow cycles. If no clear arrives within one period of enabling, reset_req_o rises, and it stays high until rst_ni.
- R9: With configuration bit 8 set, expiry and early clears raise no reset request.
- R10: Configuration bits [5:4] select the warning point: 0 off, 1 at 1/4, 2 at 1/2, 3 at 3/4 of the period. warn_o rises once the count reaches that point and falls after a clear.
- R11: Configuration bits [7:6] select the window with the same encoding as bits [5:4]. A clear applied before the window fraction of the period has elapsed raises reset_req_o, and one applied after it does not.
- R12: lp_enter_i clears cmd_busy_o in the next cycle, and a clear still in flight while it is held is not applied to the counter.
- R13: While dbg_halt_i is high the counter stops, unless configuration bit 9 is set, in which case it keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| lf_clk_i | input | 1 | Slow counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 3 | Write address |
| wdata_i | input | 32 | Write data |
| lp_enter_i | input | 1 | Low-power entry, aborts a pending clear |
| dbg_halt_i | input | 1 | Debug halt |
| err_o | output | 1 | Error response for a dropped write |
| ctrl_busy_o | output | 1 | Configuration/enable sync in progress |
| cmd_busy_o | output | 1 | Clear command sync in progress |
| disabling_o | output | 1 | Disable not yet confirmed by slow domain |
| enabled_o | output | 1 | Enable state as written |
| locked_o | output | 1 | Configuration lock state |
| warn_o | output | 1 | Early warning interrupt |
| reset_req_o | output | 1 | Sticky reset request |

## Verification
The bench targets back-to-back writes to a busy path. A design that let such a write through would silently replace a value still in flight instead of pulsing err_o. It feeds the counter at random intervals, inside and outside the window: an off-by-one threshold or a bad period decode shows up as a spurious or missing reset request. It holds low-power entry across a clear and checks that the reset still arrives on the original schedule, which a design that applied the aborted clear would postpone. It also checks that the lock really blocks disabling and that the unlock key reopens it.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  parameter int unsigned PER_W  = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned CNT_W  = (1 << PER_W) + 3;
  localparam int unsigned CFG_W  = PER_W + 2 * SEL_W + 2;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG    = 3'd0,
    A_CMD    = 3'd1,
    A_EN_SET = 3'd2,
    A_EN_CLR = 3'd3,
    A_LOCK   = 3'd4
  } wdt_addr_e;

  typedef struct packed {
    logic             dbg_run;
    logic             rst_dis;
    logic [SEL_W-1:0] win_sel;
    logic [SEL_W-1:0] warn_sel;
    logic [PER_W-1:0] per_sel;
  } wdt_cfg_t;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t wdt_period(input logic [PER_W-1:0] sel);
    return cnt_t'(1) << (int'(sel) + 3);
  endfunction

  // quarter-step fraction of the period; 0 = feature off
  function automatic cnt_t wdt_frac(input cnt_t per, input logic [SEL_W-1:0] sel);
    case (sel)
      2'd1:    return per >> 2;
      2'd2:    return per >> 1;
      2'd3:    return per - (per >> 2);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
module wdt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wdt_bus_regs.sv
`timescale 1ns/1ps
module wdt_bus_regs
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_LOCK    = 32'h0000_A5C3,
  parameter logic [DATA_W-1:0] KEY_UNLOCK  = 32'h0000_3C5A,
  parameter bit                STICKY_LOCK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lp_enter_i,
  input  logic              ctrl_ack_i,
  input  logic              cmd_ack_i,
  output wdt_cfg_t          cfg_o,
  output logic              en_o,
  output logic              ctrl_req_o,
  output logic              cmd_req_o,
  output logic              err_o,
  output logic              ctrl_busy_o,
  output logic              cmd_busy_o,
  output logic              disabling_o,
  output logic              locked_o
);
  wdt_cfg_t cfg_q;
  logic en_q, lock_q, disabling_q, err_q;
  logic ctrl_req_q, cmd_req_q, cmd_busy_q;
  logic [1:0] ack_s;
  logic ctrl_busy, cmd_pend;

  wdt_sync #(.W(2)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctrl_ack_i, cmd_ack_i}),
    .q_o   (ack_s)
  );

  assign ctrl_busy = ctrl_req_q ^ ack_s[1];
  assign cmd_pend  = cmd_req_q ^ ack_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      en_q        <= 1'b0;
      lock_q      <= 1'b0;
      disabling_q <= 1'b0;
      err_q       <= 1'b0;
      ctrl_req_q  <= 1'b0;
      cmd_req_q   <= 1'b0;
      cmd_busy_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (disabling_q && !ctrl_busy) disabling_q <= 1'b0;
      // abort keeps the toggle pending internally; only the flag drops
      if (cmd_busy_q && (lp_enter_i || !cmd_pend)) cmd_busy_q <= 1'b0;
      if (wr_i) begin
        case (wdt_addr_e'(addr_i))
          A_CFG, A_EN_SET, A_EN_CLR: begin
            if (!lock_q) begin
              if (ctrl_busy) begin
                err_q <= 1'b1;
              end else begin
                ctrl_req_q <= ~ctrl_req_q;
                if (wdt_addr_e'(addr_i) == A_CFG) begin
                  cfg_q <= wdt_cfg_t'(wdata_i[CFG_W-1:0]);
                end else if (wdt_addr_e'(addr_i) == A_EN_SET) begin
                  en_q <= 1'b1;
                end else begin
                  en_q        <= 1'b0;
                  disabling_q <= en_q;
                end
              end
            end
          end
          A_CMD: begin
            if (wdata_i[0] && en_q) begin
              if (cmd_pend) begin
                err_q <= 1'b1;
              end else begin
                cmd_req_q  <= ~cmd_req_q;
                cmd_busy_q <= 1'b1;
              end
            end
          end
          A_LOCK: begin
            if (wdata_i == KEY_LOCK) lock_q <= 1'b1;
            else if (wdata_i == KEY_UNLOCK && !STICKY_LOCK) lock_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign en_o        = en_q;
  assign ctrl_req_o  = ctrl_req_q;
  assign cmd_req_o   = cmd_req_q;
  assign err_o       = err_q;
  assign ctrl_busy_o = ctrl_busy;
  assign cmd_busy_o  = cmd_busy_q;
  assign disabling_o = disabling_q;
  assign locked_o    = lock_q;
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
  import wdt_pkg::*;
(
  input  logic     lf_clk_i,
  input  logic     rst_ni,
  input  wdt_cfg_t cfg_i,
  input  logic     en_i,
  input  logic     ctrl_req_i,
  input  logic     cmd_req_i,
  input  logic     lp_enter_i,
  input  logic     dbg_halt_i,
  output logic     ctrl_ack_o,
  output logic     cmd_ack_o,
  output logic     rst_req_o,
  output logic     warn_o
);
  logic [3:0] in_s;
  logic ctrl_s, cmd_s, lp_s, halt_s;
  logic ctrl_seen_q, cmd_seen_q;
  wdt_cfg_t cfg_s;
  logic en_s, rst_req_q, warn_q;
  cnt_t cnt_q, period, warn_thr, win_thr;
  logic ctrl_new, feed, run, expire, early;

  wdt_sync #(.W(4)) u_in_sync (
    .clk_i (lf_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctrl_req_i, cmd_req_i, lp_enter_i, dbg_halt_i}),
    .q_o   (in_s)
  );
  assign {ctrl_s, cmd_s, lp_s, halt_s} = in_s;

  assign ctrl_new = ctrl_s ^ ctrl_seen_q;
  assign feed     = (cmd_s ^ cmd_seen_q) && en_s && !lp_s;
  assign period   = wdt_period(cfg_s.per_sel);
  assign warn_thr = wdt_frac(period, cfg_s.warn_sel);
  assign win_thr  = wdt_frac(period, cfg_s.win_sel);
  assign run      = en_s && (!halt_s || cfg_s.dbg_run);
  assign expire   = run && !feed && (cnt_q >= period - cnt_t'(1));
  assign early    = feed && (cfg_s.win_sel != '0) && (cnt_q < win_thr);

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_seen_q <= 1'b0;
      cmd_seen_q  <= 1'b0;
      cfg_s       <= '0;
      en_s        <= 1'b0;
      cnt_q       <= '0;
      rst_req_q   <= 1'b0;
      warn_q      <= 1'b0;
    end else begin
      ctrl_seen_q <= ctrl_s;
      cmd_seen_q  <= cmd_s;
      // bus side holds cfg/en stable while the toggle is in flight
      if (ctrl_new) begin
        cfg_s <= cfg_i;
        en_s  <= en_i;
      end
      if (!en_s)              cnt_q <= '0;
      else if (feed || expire) cnt_q <= '0;
      else if (run)           cnt_q <= cnt_q + cnt_t'(1);
      if ((expire || early) && !cfg_s.rst_dis) rst_req_q <= 1'b1;
      warn_q <= en_s && (cfg_s.warn_sel != '0) && (cnt_q >= warn_thr);
    end
  end

  assign ctrl_ack_o = ctrl_seen_q;
  assign cmd_ack_o  = cmd_seen_q;
  assign rst_req_o  = rst_req_q;
  assign warn_o     = warn_q;
endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_LOCK    = 32'h0000_A5C3,
  parameter logic [DATA_W-1:0] KEY_UNLOCK  = 32'h0000_3C5A,
  parameter bit                STICKY_LOCK = 1'b0
) (
  input  logic              clk_i,
  input  logic              lf_clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lp_enter_i,
  input  logic              dbg_halt_i,
  output logic              err_o,
  output logic              ctrl_busy_o,
  output logic              cmd_busy_o,
  output logic              disabling_o,
  output logic              enabled_o,
  output logic              locked_o,
  output logic              warn_o,
  output logic              reset_req_o
);
  wdt_cfg_t cfg;
  logic en, ctrl_req, cmd_req, ctrl_ack, cmd_ack, rst_req_lf, warn_lf;
  logic [1:0] out_s;

  wdt_bus_regs #(
    .KEY_LOCK   (KEY_LOCK),
    .KEY_UNLOCK (KEY_UNLOCK),
    .STICKY_LOCK(STICKY_LOCK)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .lp_enter_i (lp_enter_i),
    .ctrl_ack_i (ctrl_ack),
    .cmd_ack_i  (cmd_ack),
    .cfg_o      (cfg),
    .en_o       (en),
    .ctrl_req_o (ctrl_req),
    .cmd_req_o  (cmd_req),
    .err_o      (err_o),
    .ctrl_busy_o(ctrl_busy_o),
    .cmd_busy_o (cmd_busy_o),
    .disabling_o(disabling_o),
    .locked_o   (locked_o)
  );

  wdt_core u_core (
    .lf_clk_i  (lf_clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .en_i      (en),
    .ctrl_req_i(ctrl_req),
    .cmd_req_i (cmd_req),
    .lp_enter_i(lp_enter_i),
    .dbg_halt_i(dbg_halt_i),
    .ctrl_ack_o(ctrl_ack),
    .cmd_ack_o (cmd_ack),
    .rst_req_o (rst_req_lf),
    .warn_o    (warn_lf)
  );

  wdt_sync #(.W(2)) u_out_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_req_lf, warn_lf}),
    .q_o   (out_s)
  );

  assign enabled_o   = en;
  assign reset_req_o = out_s[1];
  assign warn_o      = out_s[0];
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              lp_enter_i,
  input logic              err_o,
  input logic              ctrl_busy_o,
  input logic              cmd_busy_o,
  input logic              disabling_o,
  input logic              enabled_o,
  input logic              locked_o,
  input logic              reset_req_o
);
  logic ctrl_wr, cmd_wr;
  assign ctrl_wr = wr_i && (addr_i == A_CFG || addr_i == A_EN_SET || addr_i == A_EN_CLR);
  assign cmd_wr  = wr_i && (addr_i == A_CMD);

  assert_busy_write_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && ctrl_busy_o && !locked_o |=> err_o);

  assert_err_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i));

  assert_cmd_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !enabled_o && !cmd_busy_o |=> !cmd_busy_o && !err_o);

  assert_lock_holds_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(enabled_o));

  assert_disabling_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disabling_o) |-> !enabled_o);

  assert_rst_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> reset_req_o);

  assert_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_enter_i && !cmd_wr |=> !cmd_busy_o);
endmodule

bind wdt_top wdt_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .lp_enter_i (lp_enter_i),
  .err_o      (err_o),
  .ctrl_busy_o(ctrl_busy_o),
  .cmd_busy_o (cmd_busy_o),
  .disabling_o(disabling_o),
  .enabled_o  (enabled_o),
  .locked_o   (locked_o),
  .reset_req_o(reset_req_o)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  import wdt_pkg::*;

  localparam int SLOW = 8; // bus cycles per slow cycle
  localparam logic [31:0] K_LOCK   = 32'h0000_A5C3;
  localparam logic [31:0] K_UNLOCK = 32'h0000_3C5A;

  logic clk_i = 0, lf_clk_i = 0, rst_ni = 0;
  logic wr_i = 0, lp_enter_i = 0, dbg_halt_i = 0;
  logic [2:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic err_o, ctrl_busy_o, cmd_busy_o, disabling_o, enabled_o, locked_o, warn_o, reset_req_o;

  int n_checks = 0, n_err = 0;

  always #2 clk_i = ~clk_i;
  initial begin
    #3;
    forever #16 lf_clk_i = ~lf_clk_i;
  end

  wdt_top dut (
    .clk_i(clk_i), .lf_clk_i(lf_clk_i), .rst_ni(rst_ni), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .lp_enter_i(lp_enter_i), .dbg_halt_i(dbg_halt_i),
    .err_o(err_o), .ctrl_busy_o(ctrl_busy_o), .cmd_busy_o(cmd_busy_o),
    .disabling_o(disabling_o), .enabled_o(enabled_o), .locked_o(locked_o),
    .warn_o(warn_o), .reset_req_o(reset_req_o)
  );

  function automatic int exp_period(input int p);
    return 1 << (p + 3);
  endfunction

  function automatic int exp_frac(input int t, input int sel);
    case (sel)
      1: return t / 4;
      2: return t / 2;
      3: return t - t / 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] cfg_word(input int per, input int warn, input int win,
                                           input int rdis, input int drun);
    return 32'((drun << 9) | (rdis << 8) | (win << 6) | (warn << 4) | per);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    lp_enter_i = 0;
    dbg_halt_i = 0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, output logic e);
    @(negedge clk_i);
    wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 0;
    e = err_o;
  endtask

  // which: 0 reset_req high, 1 warn high, 2 ctrl idle, 3 cmd idle, 4 warn low
  task automatic wait_for(input int which, input int limit, output int n);
    bit done;
    n = 0;
    forever begin
      case (which)
        0: done = reset_req_o;
        1: done = warn_o;
        2: done = !ctrl_busy_o;
        3: done = !cmd_busy_o;
        default: done = !warn_o;
      endcase
      if (done || n >= limit) break;
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic start(input logic [31:0] cfg);
    logic e;
    int n;
    bus_wr(A_CFG, cfg, e);
    wait_for(2, 200, n);
    bus_wr(A_EN_SET, 32'd1, e);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    logic e;
    int n, t, p, sel, iv;
    void'($urandom(32'd2024));
    do_reset();

    // R1 reset state
    check(err_o == 0 && ctrl_busy_o == 0 && cmd_busy_o == 0, "R1 busy/err", int'(err_o), 0);
    check(disabling_o == 0 && enabled_o == 0 && locked_o == 0, "R1 state", int'(enabled_o), 0);
    check(warn_o == 0 && reset_req_o == 0, "R1 outputs", int'(reset_req_o), 0);

    // R2 / R3 control path sync and busy error
    bus_wr(A_CFG, cfg_word(4, 0, 0, 0, 0), e);
    check(ctrl_busy_o == 1 && e == 0, "R2 busy after write", int'(ctrl_busy_o), 1);
    bus_wr(A_EN_SET, 32'd1, e);
    check(e == 1, "R3 err on busy write", int'(e), 1);
    wait_for(2, 200, n);
    check(n <= 40, "R2 busy duration", n, 40);
    check(enabled_o == 0, "R3 dropped write", int'(enabled_o), 0);

    // R5 clear while disabled ignored
    bus_wr(A_CMD, 32'd1, e);
    check(e == 0 && cmd_busy_o == 0, "R5 clear when disabled", int'(cmd_busy_o), 0);

    // R4 clear and double clear
    bus_wr(A_EN_SET, 32'd1, e);
    wait_for(2, 200, n);
    bus_wr(A_CMD, 32'd1, e);
    check(cmd_busy_o == 1, "R4 cmd busy", int'(cmd_busy_o), 1);
    bus_wr(A_CMD, 32'd1, e);
    check(e == 1, "R4 err on second clear", int'(e), 1);
    wait_for(3, 200, n);
    check(n <= 40, "R4 cmd busy duration", n, 40);

    // R6 lock
    bus_wr(A_LOCK, 32'h1234_0000 | ($urandom() & 32'h0fff), e);
    check(locked_o == 0, "R6 wrong key", int'(locked_o), 0);
    bus_wr(A_LOCK, K_LOCK, e);
    check(locked_o == 1, "R6 lock key", int'(locked_o), 1);
    bus_wr(A_EN_CLR, 32'd1, e);
    check(enabled_o == 1 && ctrl_busy_o == 0 && e == 0, "R6 locked disable", int'(enabled_o), 1);
    bus_wr(A_CFG, cfg_word(0, 0, 0, 1, 0), e);
    check(ctrl_busy_o == 0 && e == 0, "R6 locked cfg", int'(ctrl_busy_o), 0);
    bus_wr(A_LOCK, K_UNLOCK, e);
    check(locked_o == 0, "R6 unlock key", int'(locked_o), 0);

    // R7 disabling handshake
    bus_wr(A_EN_CLR, 32'd1, e);
    check(enabled_o == 0 && disabling_o == 1, "R7 disabling high", int'(disabling_o), 1);
    wait_for(2, 200, n);
    @(negedge clk_i);
    check(disabling_o == 0, "R7 disabling cleared", int'(disabling_o), 0);

    // R8 timeout with random periods
    for (int k = 0; k < 4; k++) begin
      p = int'($urandom_range(0, 3));
      do_reset();
      start(cfg_word(p, 0, 0, 0, 0));
      wait_for(0, 4000, t);
      check(t >= exp_period(p) * SLOW && t <= exp_period(p) * SLOW + 64,
            "R8 timeout", t, exp_period(p) * SLOW);
    end
    repeat (50) @(negedge clk_i);
    check(reset_req_o == 1, "R8 sticky", int'(reset_req_o), 1);

    // R9 reset disabled
    do_reset();
    start(cfg_word(0, 0, 0, 1, 0));
    repeat (600) @(negedge clk_i);
    check(reset_req_o == 0, "R9 no reset", int'(reset_req_o), 0);

    // R10 warning
    sel = int'($urandom_range(1, 3));
    do_reset();
    start(cfg_word(4, sel, 0, 0, 0));
    wait_for(1, 3000, t);
    check(t >= exp_frac(128, sel) * SLOW && t <= exp_frac(128, sel) * SLOW + 64,
          "R10 warn time", t, exp_frac(128, sel) * SLOW);
    bus_wr(A_CMD, 32'd1, e);
    wait_for(4, 200, n);
    check(n <= 80 && warn_o == 0, "R10 warn cleared", n, 80);
    check(reset_req_o == 0, "R10 no reset", int'(reset_req_o), 0);

    // R11 window: early and late clears
    do_reset();
    start(cfg_word(4, 0, 2, 0, 0));
    repeat (20 * SLOW) @(negedge clk_i);
    bus_wr(A_CMD, 32'd1, e);
    wait_for(0, 100, n);
    check(reset_req_o == 1, "R11 early clear", int'(reset_req_o), 1);
    do_reset();
    start(cfg_word(4, 0, 2, 0, 0));
    repeat (80 * SLOW) @(negedge clk_i);
    bus_wr(A_CMD, 32'd1, e);
    repeat (100) @(negedge clk_i);
    check(reset_req_o == 0, "R11 late clear", int'(reset_req_o), 0);

    // R8/R11 random feeding inside the legal window
    for (int k = 0; k < 3; k++) begin
      p = int'($urandom_range(3, 4));
      do_reset();
      start(cfg_word(p, 0, 1, 0, 0));
      for (int f = 0; f < 6; f++) begin
        iv = int'($urandom_range(exp_period(p) / 4 + 6, exp_period(p) - 12));
        repeat (iv * SLOW - 2) @(negedge clk_i);
        bus_wr(A_CMD, 32'd1, e);
      end
      repeat (20) @(negedge clk_i);
      check(reset_req_o == 0, "R8 R11 random feeding", int'(reset_req_o), 0);
    end

    // R12 low-power abort
    do_reset();
    start(cfg_word(4, 0, 0, 0, 0));
    t = 0;
    repeat (400) @(negedge clk_i);
    lp_enter_i = 1;
    repeat (40) @(negedge clk_i);
    bus_wr(A_CMD, 32'd1, e);
    @(negedge clk_i);
    check(cmd_busy_o == 0, "R12 busy cleared", int'(cmd_busy_o), 0);
    wait_for(0, 2000, n);
    t = 443 + n;
    check(reset_req_o == 1 && t <= 128 * SLOW + 64, "R12 clear not applied", t, 128 * SLOW);
    lp_enter_i = 0;

    // R13 debug halt
    do_reset();
    dbg_halt_i = 1;
    start(cfg_word(0, 0, 0, 0, 0));
    repeat (400) @(negedge clk_i);
    check(reset_req_o == 0, "R13 halted", int'(reset_req_o), 0);
    dbg_halt_i = 0;
    wait_for(0, 400, n);
    check(reset_req_o == 1 && n <= 8 * SLOW + 64, "R13 resumes", n, 8 * SLOW);
    do_reset();
    dbg_halt_i = 1;
    start(cfg_word(0, 0, 0, 0, 1));
    wait_for(0, 400, n);
    check(reset_req_o == 1 && n <= 8 * SLOW + 64, "R13 debug run", n, 8 * SLOW);
    dbg_halt_i = 0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule